// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

The controller gathers sixty-four interrupt input lines into two 32-bit banks and drives a single interrupt request toward a processor. Every bank keeps a latched-event word, an enable mask, a sampled copy of its input levels and a fixed set of level-sensitive bits. A level-sensitive bit is pending for exactly as long as its input stays high. Any other bit latches on a high input and stays pending until software acknowledges it.

Software reaches the banks through a small full-word register port that has separate read and write strobes. It reads events, mask and levels, writes the mask, and acknowledges events by writing ones to the bits it wants cleared. The port accepts one access every cycle and has no back-pressure: a strobe is taken in the cycle it is high. Read data returns one cycle later with a one-cycle valid pulse. The interrupt output is registered. It is high whenever an enabled bit in either bank is pending.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: Input line k is stored in bank 1-(k>>5) at bit k&31, so lines 0..31 land in bank 1 and lines 32..63 land in bank 0.
- R2: At each clock edge, each bank's levels word takes the current value of its 32 input lines, including clearing bits whose line is low.
- R3: A high input on a bit that is not level-sensitive sets that bit in the events word, and the bit stays set after the input goes low.
- R4: The level-sensitive bits are fixed at reset to 0x00000000 for bank 0 and 0x1FF00000 for bank 1. They never appear in the events word, they are pending from their live level, and an acknowledge has no effect on them.
- R5: A write to offset 0x8 clears the events bits that are set in the write data, except level-sensitive bits. If the same bit's input is high in that cycle, the bit stays set.
- R6: irq_out is high in the cycle after a state in which ((events | (levels & levelsensitive)) & mask) is nonzero in either bank, and low otherwise.
- R7: The bank index is (addr - 0x10) >> 4, taken modulo 4096. Index 0 covers 0x10..0x1F and index 1 covers 0x20..0x2F. An index of 2 or more reads as zero and ignores writes. Offsets 0x0 (events), 0x4 (mask) and 0xC (levels) are readable. Every other offset, including 0x8, reads zero.
- R8: reg_rdata_vld is high exactly one cycle after reg_rd_en, and reg_rdata holds the register value from the cycle of the request.
- R9: After reset, events, mask and levels are zero in both banks, and irq_out and reg_rdata_vld are low.
- R10: A write to offset 0x4 replaces the bank's whole 32-bit mask with the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 64 | Interrupt input lines, sampled every cycle |
| reg_wr_en | input | 1 | Write strobe, one full-word write per high cycle |
| reg_rd_en | input | 1 | Read strobe, one full-word read per high cycle |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rdata_vld |
| reg_rdata_vld | output | 1 | Read data valid, one cycle after reg_rd_en |
| irq_out | output | 1 | Registered interrupt request |

## Verification
An input value or a register write presented before a rising edge appears in the bank state at that edge. A read issued in the following cycle returns it one edge later. irq_out reflects a state change one edge after the state itself changes, and reg_rdata_vld follows reg_rd_en by exactly one edge. The bench steps a model of the banks in the same cycle it drives each stimulus. It records the expected output from the state before that edge, and compares at the falling edge that follows. Directed sequences cover the lane mapping, acknowledge against simultaneous set, level-sensitive bits and out-of-range addresses, and a long seeded random run covers the rest.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic [3:0] {
    OFS_EVT = 4'h0,
    OFS_MSK = 4'h4,
    OFS_ACK = 4'h8,
    OFS_LVL = 4'hC
  } reg_ofs_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic [3:0]           ofs,
  output logic                 idx_ok,
  output logic [NUM_BANKS-1:0] mask_we,
  output logic [NUM_BANKS-1:0] ack_we
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;

  // subtracting 0x10 leaves the low nibble intact, so only the upper part moves
  assign idx    = addr[ADDR_W-1:4] - IDX_W'(1);
  assign idx_ok = idx < IDX_W'(NUM_BANKS);
  assign ofs    = addr[3:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign bank_sel[b] = idx_ok && (idx == IDX_W'(b));
    assign mask_we[b]  = wr_en && bank_sel[b] && (ofs == OFS_MSK);
    assign ack_we[b]   = wr_en && bank_sel[b] && (ofs == OFS_ACK);
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int                BANK_W  = 32,
  parameter logic [BANK_W-1:0] LT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] line_in,
  input  logic              mask_we,
  input  logic              ack_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] events_q,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] levels_q,
  output logic              pending
);
  logic [BANK_W-1:0] edge_set;
  logic [BANK_W-1:0] ack_clr;
  logic              seen_q;

  assign edge_set = line_in & ~LT_MASK;
  assign ack_clr  = ack_we ? (wdata & ~LT_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      events_q <= '0;
      mask_q   <= '0;
      levels_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      seen_q   <= 1'b1;
      levels_q <= line_in;
      // a new edge beats an acknowledge of the same bit
      events_q <= (events_q & ~ack_clr) | edge_set;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign pending = |((events_q | (levels_q & LT_MASK)) & mask_q);

  // R2
  levels_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> levels_q == $past(line_in));

  // R4
  lt_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (events_q & LT_MASK) == '0);

  // R3
  edge_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (levels_q & ~LT_MASK & ~events_q) == '0);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> (events_q & $past(wdata & ~LT_MASK & ~line_in)) == '0);

  // R10
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(wdata));
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int                BANK_W   = 32,
  parameter int                ADDR_W   = 12,
  parameter logic [BANK_W-1:0] LT_BANK0 = '0,
  parameter logic [BANK_W-1:0] LT_BANK1 = 32'h1FF0_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   irq_lines,
  input  logic                          reg_wr_en,
  input  logic                          reg_rd_en,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [BANK_W-1:0]             reg_wdata,
  output logic [BANK_W-1:0]             reg_rdata,
  output logic                          reg_rdata_vld,
  output logic                          irq_out
);
  logic [NUM_BANKS-1:0]        bank_sel;
  logic [3:0]                  ofs;
  logic                        idx_ok;
  logic [NUM_BANKS-1:0]        mask_we;
  logic [NUM_BANKS-1:0]        ack_we;
  logic [BANK_W-1:0]           evt_q [NUM_BANKS];
  logic [BANK_W-1:0]           msk_q [NUM_BANKS];
  logic [BANK_W-1:0]           lvl_q [NUM_BANKS];
  logic [NUM_BANKS-1:0]        pend;
  logic [NUM_BANKS*BANK_W-1:0] mask_all;
  logic [BANK_W-1:0]           rd_val;
  logic                        any_pend;

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (reg_addr),
    .wr_en    (reg_wr_en),
    .bank_sel (bank_sel),
    .ofs      (ofs),
    .idx_ok   (idx_ok),
    .mask_we  (mask_we),
    .ack_we   (ack_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // banks are numbered opposite to the input lines
    irqc_bank #(
      .BANK_W  (BANK_W),
      .LT_MASK ((b == 1) ? LT_BANK1 : LT_BANK0)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (irq_lines[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
      .mask_we  (mask_we[b]),
      .ack_we   (ack_we[b]),
      .wdata    (reg_wdata),
      .events_q (evt_q[b]),
      .mask_q   (msk_q[b]),
      .levels_q (lvl_q[b]),
      .pending  (pend[b])
    );
    assign mask_all[b*BANK_W +: BANK_W] = msk_q[b];
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) begin
        case (ofs)
          OFS_EVT: rd_val = evt_q[b];
          OFS_MSK: rd_val = msk_q[b];
          OFS_LVL: rd_val = lvl_q[b];
          default: rd_val = '0;
        endcase
      end
    end
  end

  assign any_pend = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata     <= '0;
      reg_rdata_vld <= 1'b0;
      irq_out       <= 1'b0;
    end else begin
      reg_rdata_vld <= reg_rd_en;
      reg_rdata     <= reg_rd_en ? rd_val : '0;
      irq_out       <= any_pend;
    end
  end

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rdata_vld);

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> irq_out);

  // R7
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !idx_ok) |=> $stable(mask_all));
endmodule

// File: tb/sim_dual_bank_irq_ctrl.sv
module sim_dual_bank_irq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_lines = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rdata_vld;
  logic        irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] m_ev [2];
  logic [31:0] m_mk [2];
  logic [31:0] m_lv [2];
  logic [31:0] m_lt [2];
  logic [63:0] cur_ln = '0;

  always #(CLK_P/2) clk = ~clk;

  dual_bank_irq_ctrl u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_lines     (irq_lines),
    .reg_wr_en     (reg_wr_en),
    .reg_rd_en     (reg_rd_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .reg_rdata_vld (reg_rdata_vld),
    .irq_out       (irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // R7 decode: index = ((addr - 0x10) mod 4096) >> 4
  function automatic int m_idx(input logic [11:0] a);
    logic [11:0] r;
    r = a - 12'h010;
    return int'(r[11:4]);
  endfunction

  function automatic logic m_pend();
    logic p;
    p = 1'b0;
    for (int b = 0; b < 2; b++)
      if (((m_ev[b] | (m_lv[b] & m_lt[b])) & m_mk[b]) != 0) p = 1'b1;
    return p;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int i;
    i = m_idx(a);
    if (i >= 2) return '0;
    case (a[3:0])
      4'h0: return m_ev[i];
      4'h4: return m_mk[i];
      4'hC: return m_lv[i];
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [11:0] a);
    if (m_idx(a) >= 2) return "R7";
    case (a[3:0])
      4'h0: return "R3";
      4'h4: return "R10";
      4'hC: return "R2";
      default: return "R7";
    endcase
  endfunction

  task automatic m_step(input logic [63:0] ln, input logic wr, input logic [11:0] a,
                        input logic [31:0] wd);
    int i;
    i = m_idx(a);
    for (int b = 0; b < 2; b++) begin
      logic [31:0] lb, clr;
      lb  = (b == 0) ? ln[63:32] : ln[31:0];   // R1 lane mapping
      clr = (wr && i == b && a[3:0] == 4'h8) ? (wd & ~m_lt[b]) : '0;
      m_ev[b] = (m_ev[b] & ~clr) | (lb & ~m_lt[b]);
      if (wr && i == b && a[3:0] == 4'h4) m_mk[b] = wd;
      m_lv[b] = lb;
    end
  endtask

  // one clock cycle of stimulus; checks outputs at the following falling edge
  task automatic cyc(input logic wr, input logic rd, input logic [11:0] a, input logic [31:0] wd);
    logic        e_irq;
    logic [31:0] e_rd;
    irq_lines = cur_ln;
    reg_wr_en = wr;
    reg_rd_en = rd;
    reg_addr  = a;
    reg_wdata = wd;
    e_irq = m_pend();
    e_rd  = rd ? m_read(a) : '0;
    m_step(cur_ln, wr, a, wd);
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_rd_en = 1'b0;
    check("R6", {31'b0, irq_out}, {31'b0, e_irq});
    check("R8", {31'b0, reg_rdata_vld}, {31'b0, rd});
    if (rd) check(rd_tag(a), reg_rdata, e_rd);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 12'h000, '0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d);
  endtask

  task automatic rdx(input logic [11:0] a, input logic [31:0] exp, input string req);
    cyc(1'b0, 1'b1, a, '0);
    check(req, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    m_lt[0] = 32'h0000_0000;
    m_lt[1] = 32'h1FF0_0000;
    for (int b = 0; b < 2; b++) begin
      m_ev[b] = '0; m_mk[b] = '0; m_lv[b] = '0;
    end
    repeat (3) @(negedge clk);
    check("R9", {31'b0, irq_out}, 32'd0);
    check("R9", {31'b0, reg_rdata_vld}, 32'd0);
    rst_n = 1'b1;
    rdx(12'h010, 32'h0, "R9");
    rdx(12'h024, 32'h0, "R9");
    rdx(12'h02C, 32'h0, "R9");

    // R1: line 0 to bank 1 bit 0, line 32 to bank 0 bit 0
    cur_ln = 64'h1;
    idle();
    rdx(12'h02C, 32'h1, "R1");
    rdx(12'h01C, 32'h0, "R1");
    cur_ln = 64'h1 << 32;
    idle();
    rdx(12'h01C, 32'h1, "R1");
    rdx(12'h02C, 32'h0, "R2");
    rdx(12'h020, 32'h1, "R3");
    rdx(12'h010, 32'h1, "R3");

    // R5: acknowledge, then acknowledge against a live edge
    cur_ln = '0;
    wr(12'h018, 32'h1);
    rdx(12'h010, 32'h0, "R5");
    wr(12'h028, 32'h1);
    rdx(12'h020, 32'h0, "R5");
    cur_ln = 64'h1 << 32;
    wr(12'h018, 32'h1);
    cur_ln = '0;
    rdx(12'h010, 32'h1, "R5");
    wr(12'h018, 32'h1);

    // R4: line 20 is level-sensitive in bank 1
    cur_ln = 64'h1 << 20;
    wr(12'h024, 32'h0010_0000);
    idle();
    check("R4", {31'b0, irq_out}, 32'd1);
    rdx(12'h020, 32'h0, "R4");
    wr(12'h028, 32'hFFFF_FFFF);
    idle();
    check("R4", {31'b0, irq_out}, 32'd1);
    cur_ln = '0;
    idle();
    idle();
    check("R4", {31'b0, irq_out}, 32'd0);

    // R6: latched edge keeps the request up until acknowledged
    cur_ln = 64'h1 << 33;
    wr(12'h014, 32'h2);
    cur_ln = '0;
    idle();
    idle();
    check("R6", {31'b0, irq_out}, 32'd1);
    wr(12'h018, 32'h2);
    idle();
    check("R6", {31'b0, irq_out}, 32'd0);

    // R7: out-of-range index and unreadable offsets
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    rdx(12'h014, 32'h2, "R7");
    rdx(12'h024, 32'h0010_0000, "R7");
    rdx(12'h034, 32'h0, "R7");
    rdx(12'h018, 32'h0, "R7");
    rdx(12'h012, 32'h0, "R7");

    // R10
    wr(12'h014, 32'hA5A5_0F0F);
    rdx(12'h014, 32'hA5A5_0F0F, "R10");

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic        w, r;
      case ($urandom % 12)
        0: a = 12'h010;  1: a = 12'h014;  2: a = 12'h018;  3: a = 12'h01C;
        4: a = 12'h020;  5: a = 12'h024;  6: a = 12'h028;  7: a = 12'h02C;
        8: a = 12'h034;  9: a = 12'h008;  10: a = 12'h012;
        default: a = 12'($urandom);
      endcase
      cur_ln = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      w = ($urandom % 4) == 0;
      r = ($urandom % 2) == 0;
      cyc(w, r, a, $urandom);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule